// File: doc/BRIEF.md
# Interrupt Redirection Register Window

This block is the register file of an I/O interrupt controller, reached through a 32-bit bus that uses an index register and a data window. The bus side writes an 8-bit index into the select register and then reads or writes the data window. The register chosen by the index is one of four kinds: an identity register, a read-only version register, a read-only arbitration register, or one half of the 64-bit redirection entry kept for each interrupt input pin. The block keeps the whole table in flops and shows every entry in parallel on `entries_o`. It also raises a one-cycle strobe for each pin whose entry was just written, so that the delivery logic next to it can re-evaluate that pin.

Two status bits in each entry belong to the delivery logic and the bus cannot write them. The busy bit (bit 12) follows `dlv_busy`. The in-service bit (bit 14) is set through `rirr_set`, but only while the entry is level triggered. Whenever a write leaves an entry edge triggered, the in-service bit is cleared.

Requests use a valid/ready handshake and responses use a second one. Each accepted request produces exactly one response beat, writes included. A response that is not yet taken holds its data steady and stops new requests. `req_ready` is high whenever the response slot is empty or is being drained in the same cycle. An access is honoured only when `req_size` is 4 (bytes). Any other size is accepted and answered with zero data, and it changes nothing.

Top module: `irq_redir_regs`

## Requirements
- R1: A write to offset 0x00 with size 4 stores `req_wdata[7:0]` as the index, dropping the upper bits. A read at 0x00 returns the index zero-extended. The index resets to 0.
- R2: Offset 0x10 is the data window and acts on the indexed register. A read at any other offset returns 0xFFFFFFFF, and a write at any other offset changes nothing.
- R3: A request whose `req_size` is not 4 is answered with data 0 and changes no index, identity or table state.
- R4: A window write at index 0x00 stores `wdata[27:24]` as the identity. Reads at index 0x00 and at index 0x02 both return the identity in bits 27:24 and zero elsewhere. Writes at index 0x02 are ignored. The identity resets to 0.
- R5: A read at index 0x01 returns 0x11 in bits 7:0 and NPINS-1 in bits 23:16, with all other bits 0. Writes at index 0x01 are ignored.
- R6: Pin p's entry has its low word at index 0x10+2p and its high word at index 0x11+2p. A write to the high word stores all 32 bits. Indices 0x03 to 0x0F, and indices past the last entry, read as 0 and ignore writes.
- R7: A low-word write stores every bit except bit 12 and bit 14. Bit 12 always reads as `dlv_busy[p]` as it was one cycle earlier. Bit 14 keeps its stored value. A `rirr_set[p]` pulse sets bit 14 only while bit 15 (trigger, 1 = level) is 1.
- R8: If bit 15 is 0 after a write to an entry, bit 14 of that entry is 0 from the next cycle on.
- R9: After reset every entry equals 0x0001000000010000, which means bit 16 (mask) and bit 48 are set.
- R10: `entry_upd[p]` is high for exactly the one cycle after a window write to either word of pin p is accepted. At most one bit is ever high.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. Each accepted request gives one response the next cycle, and while `rsp_valid && !rsp_ready` the response data stays stable.
- R12: `entries_o[64p+63:64p]` always equals pin p's stored entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset: 0x00 index, 0x10 window |
| req_size | input | 3 | Access size in bytes; only 4 is honoured |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 32 | Read data (0 for writes and rejected sizes) |
| rirr_set | input | NPINS | Per-pin in-service set pulse from delivery logic |
| dlv_busy | input | NPINS | Per-pin delivery busy level |
| entry_upd | output | NPINS | Per-pin one-cycle entry-written strobe |
| entries_o | output | NPINS*64 | All entries, pin p at bits 64p+63:64p |

## Verification
On every cycle, assertions check the protected-bit merge on low-word writes, that the in-service bit is dropped after an edge-trigger write, that high words are stored as written, that the index captures its written byte and survives rejected sizes, that the strobe is at most one-hot, and that stalled responses hold. The bench sweeps all 256 index values on a four-pin instance and computes every expected read arithmetically, which covers the decode holes and the area past the table. Only its scenarios show the version and identity encodings, the responses at unmapped offsets, the write-then-read round trips through the window, and the timing of the strobe.

// File: rtl/irr_pkg.sv
package irr_pkg;
  localparam logic [7:0]  OFS_SEL   = 8'h00;
  localparam logic [7:0]  OFS_WIN   = 8'h10;
  localparam logic [7:0]  IDX_ID    = 8'h00;
  localparam logic [7:0]  IDX_VER   = 8'h01;
  localparam logic [7:0]  IDX_ARB   = 8'h02;
  localparam int          IDX_TBL   = 16;
  localparam logic [7:0]  VER_CODE  = 8'h11;
  localparam logic [2:0]  SIZE_WORD = 3'd4;
  localparam logic [63:0] ENT_RST   = 64'h0001_0000_0001_0000;
  localparam logic [31:0] LO_RO     = 32'h0000_5000;
  localparam int          B_BUSY    = 12;
  localparam int          B_INSV    = 14;
  localparam int          B_TRIG    = 15;
endpackage

// File: rtl/irr_bus_if.sv
module irr_bus_if
  import irr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [2:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  input  logic [31:0] win_rdata,
  output logic [7:0]  sel,
  output logic        win_wr
);
  logic accept, good, sel_wr;
  logic [31:0] rd_next;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign good      = (req_size == SIZE_WORD);
  assign sel_wr    = accept && good && req_write && (req_addr == OFS_SEL);
  assign win_wr    = accept && good && req_write && (req_addr == OFS_WIN);

  always_comb begin
    if (!good || req_write)        rd_next = '0;
    else if (req_addr == OFS_SEL)  rd_next = {24'h0, sel};
    else if (req_addr == OFS_WIN)  rd_next = win_rdata;
    else                           rd_next = 32'hFFFF_FFFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel       <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      if (sel_wr) sel <= req_wdata[7:0];
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_next;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  assert_sel_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> (sel == $past(req_wdata[7:0])));
  assert_bad_size_keeps_sel_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !good) |=> $stable(sel));
endmodule

// File: rtl/irr_entry.sv
module irr_entry
  import irr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_set,
  input  logic        dlv_busy,
  output logic [63:0] ent
);
  logic [63:0] nxt;

  always_comb begin
    nxt = ent;
    if (wr_lo) nxt[31:0]  = (ent[31:0] & LO_RO) | (wdata & ~LO_RO);
    if (wr_hi) nxt[63:32] = wdata;
    nxt[B_INSV] = nxt[B_TRIG] & (nxt[B_INSV] | rirr_set);
    nxt[B_BUSY] = dlv_busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ent <= ENT_RST;
    else        ent <= nxt;
  end

  assert_lo_merge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !rirr_set) |=> (ent[B_INSV] == ($past(ent[B_INSV]) && $past(wdata[B_TRIG]))));
  assert_edge_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_lo && !wdata[B_TRIG]) |=> !ent[B_INSV]);
  assert_hi_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (ent[63:32] == $past(wdata)));
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irr_pkg::*;
#(
  parameter int NPINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [7:0]          req_addr,
  input  logic [2:0]          req_size,
  input  logic [31:0]         req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [31:0]         rsp_rdata,
  input  logic [NPINS-1:0]    rirr_set,
  input  logic [NPINS-1:0]    dlv_busy,
  output logic [NPINS-1:0]    entry_upd,
  output logic [NPINS*64-1:0] entries_o
);
  localparam int TBL_END = IDX_TBL + 2 * NPINS;
  localparam logic [7:0] MAXPIN = 8'(NPINS - 1);

  logic [7:0]  sel;
  logic        win_wr;
  logic [31:0] win_rdata, tbl_rd;
  logic [3:0]  id_q;
  logic        tbl_hit;
  logic [7:0]  tbl_off;
  logic [6:0]  pin_idx;
  logic [63:0] ent [NPINS];
  logic [NPINS-1:0] wr_lo, wr_hi;

  irr_bus_if u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .win_rdata(win_rdata), .sel(sel), .win_wr(win_wr)
  );

  assign tbl_hit = (int'(sel) >= IDX_TBL) && (int'(sel) < TBL_END);
  assign tbl_off = sel - 8'(IDX_TBL);
  assign pin_idx = tbl_off[7:1];

  genvar gi;
  generate
    for (gi = 0; gi < NPINS; gi++) begin : g_pin
      assign wr_lo[gi] = win_wr && tbl_hit && (pin_idx == 7'(gi)) && !sel[0];
      assign wr_hi[gi] = win_wr && tbl_hit && (pin_idx == 7'(gi)) &&  sel[0];
      irr_entry u_ent (
        .clk(clk), .rst_n(rst_n),
        .wr_lo(wr_lo[gi]), .wr_hi(wr_hi[gi]), .wdata(req_wdata),
        .rirr_set(rirr_set[gi]), .dlv_busy(dlv_busy[gi]),
        .ent(ent[gi])
      );
      assign entries_o[gi*64 +: 64] = ent[gi];
    end
  endgenerate

  always_comb begin
    tbl_rd = '0;
    for (int i = 0; i < NPINS; i++)
      if (pin_idx == 7'(i)) tbl_rd = sel[0] ? ent[i][63:32] : ent[i][31:0];
  end

  always_comb begin
    if (sel == IDX_ID || sel == IDX_ARB) win_rdata = {4'h0, id_q, 24'h0};
    else if (sel == IDX_VER)             win_rdata = {8'h0, MAXPIN, 8'h0, VER_CODE};
    else if (tbl_hit)                    win_rdata = tbl_rd;
    else                                 win_rdata = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q      <= '0;
      entry_upd <= '0;
    end else begin
      if (win_wr && sel == IDX_ID) id_q <= req_wdata[27:24];
      entry_upd <= wr_lo | wr_hi;
    end
  end

  assert_upd_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(entry_upd));
  assert_id_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr && sel == IDX_ID) |=> (id_q == $past(req_wdata[27:24])));
  assert_id_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_wr && sel == IDX_ID) |=> $stable(id_q));
endmodule

// File: tb/sim_irq_redir_regs.sv
module sim_irq_redir_regs;
  localparam int NP = 4;
  localparam time TCK = 4ns;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [7:0] req_addr = 0;
  logic [2:0] req_size = 4;
  logic [31:0] req_wdata = 0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_rdata;
  logic [NP-1:0] rirr_set = 0, dlv_busy = 0, entry_upd;
  logic [NP*64-1:0] entries_o;

  irq_redir_regs #(.NPINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .rirr_set(rirr_set), .dlv_busy(dlv_busy),
    .entry_upd(entry_upd), .entries_o(entries_o)
  );

  always #(TCK/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_lo [NP];
  logic [31:0] m_hi [NP];
  logic [3:0]  m_id;
  logic [NP-1:0] upd_seen;
  logic got_rsp;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input logic wr, input logic [7:0] a, input logic [2:0] sz,
                     input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    got_rsp = rsp_valid; r = rsp_rdata; upd_seen = entry_upd;
    req_valid = 0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_win(input int idx);
    int p;
    logic [31:0] v;
    if (idx == 0 || idx == 2) return {4'h0, m_id, 24'h0};
    if (idx == 1) return {8'h0, 8'(NP - 1), 8'h0, 8'h11};
    if (idx >= 16 && idx < 16 + 2 * NP) begin
      p = (idx - 16) / 2;
      if (idx % 2 == 1) return m_hi[p];
      v = m_lo[p];
      v[12] = dlv_busy[p];
      return v;
    end
    return 32'h0;
  endfunction

  task automatic model_lo(input int p, input logic [31:0] d);
    m_lo[p] = (m_lo[p] & 32'h5000) | (d & ~32'h5000);
    if (!m_lo[p][15]) m_lo[p][14] = 1'b0;
  endtask

  logic [31:0] r;

  initial begin : watchdog
    #(TCK * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin m_lo[p] = 32'h0001_0000; m_hi[p] = 32'h0001_0000; end
    m_id = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 R12 R11 reset state
    check("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check("R10 reset entry_upd", 64'(entry_upd), 64'd0);
    for (int p = 0; p < NP; p++)
      check("R9 R12 reset entry", entries_o[p*64 +: 64], 64'h0001_0000_0001_0000);
    bus(0, 8'h00, 4, 0, r);
    check("R1 reset select", 64'(r), 64'd0);
    check("R11 one response", 64'(got_rsp), 64'd1);

    // R1 R4 R5 R6 R9 sweep of every index at reset
    for (int v = 0; v < 256; v++) begin
      bus(1, 8'h00, 4, {24'hA5C3E1, 8'(v)}, r);
      check("R1 write response zero", 64'(r), 64'd0);
      bus(0, 8'h00, 4, 0, r);
      check("R1 select readback", 64'(r), 64'(v));
      bus(0, 8'h10, 4, 0, r);
      check("R4 R5 R6 R9 window sweep", 64'(r), 64'(exp_win(v)));
    end

    // R2 unmapped offsets
    bus(1, 8'h00, 4, 32'h01, r);
    foreach (r[i]) ;
    bus(0, 8'h04, 4, 0, r);  check("R2 read 0x04", 64'(r), 64'hFFFF_FFFF);
    bus(0, 8'h20, 4, 0, r);  check("R2 read 0x20", 64'(r), 64'hFFFF_FFFF);
    bus(0, 8'hFF, 4, 0, r);  check("R2 read 0xFF", 64'(r), 64'hFFFF_FFFF);
    bus(1, 8'h08, 4, 32'h77, r);
    bus(0, 8'h00, 4, 0, r);  check("R2 write elsewhere ignored", 64'(r), 64'h01);

    // R3 rejected sizes
    bus(1, 8'h00, 2, 32'h55, r);
    bus(0, 8'h00, 4, 0, r);  check("R3 bad-size write ignored", 64'(r), 64'h01);
    bus(0, 8'h00, 1, 0, r);  check("R3 bad-size read zero", 64'(r), 64'h0);
    bus(1, 8'h00, 4, 32'h00, r);
    bus(1, 8'h10, 2, 32'h0F00_0000, r);
    bus(0, 8'h10, 4, 0, r);  check("R3 bad-size id unchanged", 64'(r), 64'h0);

    // R4 R5 identity, arbitration, version
    bus(1, 8'h10, 4, 32'hF5A3_0000, r); m_id = 4'h5;
    bus(0, 8'h10, 4, 0, r);  check("R4 id read", 64'(r), 64'h0500_0000);
    bus(1, 8'h00, 4, 32'h02, r);
    bus(1, 8'h10, 4, 32'h0C00_0000, r);
    bus(0, 8'h10, 4, 0, r);  check("R4 arb read-only", 64'(r), 64'h0500_0000);
    bus(1, 8'h00, 4, 32'h01, r);
    bus(1, 8'h10, 4, 32'hFFFF_FFFF, r);
    bus(0, 8'h10, 4, 0, r);  check("R5 version read-only", 64'(r), 64'h0003_0011);

    // R6 R7 R8 R10 R12 every pin, both words
    for (int p = 0; p < NP; p++) begin
      logic [31:0] hv, lv;
      hv = 32'h1234_5600 + 32'(p * 17);
      lv = 32'h0000_FFFF ^ 32'(p << 4);
      bus(1, 8'h00, 4, 32'(16 + 2 * p + 1), r);
      bus(1, 8'h10, 4, hv, r); m_hi[p] = hv;
      check("R10 strobe hi", 64'(upd_seen), 64'(1 << p));
      check("R10 strobe one cycle", 64'(entry_upd), 64'd0);
      bus(1, 8'h00, 4, 32'(16 + 2 * p), r);
      bus(1, 8'h10, 4, lv, r); model_lo(p, lv);
      check("R10 strobe lo", 64'(upd_seen), 64'(1 << p));
      bus(0, 8'h10, 4, 0, r);
      check("R7 lo readback", 64'(r), 64'(exp_win(16 + 2 * p)));
      check("R12 entries_o", entries_o[p*64 +: 64], {m_hi[p], exp_win(16 + 2 * p)});
    end

    // R7 R8 protected bits on pin 2
    bus(1, 8'h00, 4, 32'h14, r);
    bus(1, 8'h10, 4, 32'h0000_8031, r); model_lo(2, 32'h0000_8031);
    @(negedge clk); rirr_set[2] = 1; @(negedge clk); rirr_set[2] = 0;
    m_lo[2][14] = 1'b1;
    bus(0, 8'h10, 4, 0, r);  check("R7 insv set when level", 64'(r[14]), 64'd1);
    dlv_busy[2] = 1;
    bus(1, 8'h10, 4, 32'h0000_8042, r); model_lo(2, 32'h0000_8042);
    bus(0, 8'h10, 4, 0, r);  check("R7 lo write keeps 12/14", 64'(r), 64'(exp_win(20)));
    check("R7 busy mirrored", 64'(r[12]), 64'd1);
    bus(1, 8'h10, 4, 32'h0000_0042, r); model_lo(2, 32'h0000_0042);
    bus(0, 8'h10, 4, 0, r);  check("R8 edge clears insv", 64'(r[14]), 64'd0);
    @(negedge clk); rirr_set[2] = 1; @(negedge clk); rirr_set[2] = 0;
    bus(0, 8'h10, 4, 0, r);  check("R7 insv not set when edge", 64'(r), 64'(exp_win(20)));
    dlv_busy[2] = 0;

    // R6 holes and past-table writes
    bus(1, 8'h00, 4, 32'h18, r);
    bus(1, 8'h10, 4, 32'hDEAD_BEEF, r);
    check("R10 no strobe past table", 64'(upd_seen), 64'd0);
    bus(0, 8'h10, 4, 0, r);  check("R6 past table reads 0", 64'(r), 64'd0);
    bus(1, 8'h00, 4, 32'h07, r);
    bus(0, 8'h10, 4, 0, r);  check("R6 hole reads 0", 64'(r), 64'd0);
    for (int p = 0; p < NP; p++)
      check("R6 R12 table intact", entries_o[p*64 +: 64], {m_hi[p], exp_win(16 + 2 * p)});

    // R11 back-pressure
    rsp_ready = 0;
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'h00; req_size = 4;
    @(negedge clk);
    req_valid = 0;
    check("R11 rsp present", 64'(rsp_valid), 64'd1);
    r = rsp_rdata;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 stall holds", {31'd0, rsp_valid, req_ready, rsp_rdata}, {31'd0, 1'b1, 1'b0, r});
    end
    rsp_ready = 1;
    @(negedge clk);
    check("R11 drained", 64'(rsp_valid), 64'd0);
    check("R1 stalled read value", 64'(r), 64'h07);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule